// File: doc/BRIEF.md
# Byte-Wide Loader for Four Double-Buffered Converter Channels

This block sits between an 8-bit processor write bus and four 12-bit converter channels. Each channel owns a staging register, filled in two pieces (a low byte and a high nibble), and a code register that drives the converter. The processor assembles new codes in the staging registers over several bus writes. It then commits every channel's staged value to its code register in a single edge, so all converter codes change together.

The upper address bits are matched against a base address. The lowest local bit picks low byte or high nibble, the next bits pick the channel, and the bit above them requests a commit of all channels. A mode input enables a chained scheme instead. With it, the broadcast address is dead, and a low-byte write to the last channel both stores that byte and commits every channel in the same edge. The written byte is then already part of the committed code.

Top module: `dac_bus_loader`

## Requirements
- R1: While reset (rst_n low) is held, every code output reads 0x800 and every staging register is cleared. A commit issued directly after reset therefore drives all codes to 0x000.
- R2: A write with address bit 0 = 0, bit 3 = 0 and channel number in bits 2..1 stores wr_data[7:0] as code bits 7..0 of that channel's staging register.
- R3: A write with address bit 0 = 1 and bit 3 = 0 stores wr_data[3:0] as code bits 11..8 of the selected channel's staging register. wr_data[7:4] is ignored.
- R4: Staging writes never alter any code output until a commit takes place.
- R5: With chain_mode = 0, a write with address bit 3 = 1 copies all four staging registers to their code outputs at that clock edge. Address bits 2..0 are ignored.
- R6: A write whose address bits 15..4 differ from the base value 0xA50 changes no register.
- R7: A cycle with wr_stb low changes no register. Each cycle with wr_stb high is one write, and it takes effect at that rising edge.
- R8: With chain_mode = 1, a low-byte write to channel 3 stores the byte and commits all channels in the same edge. Channel 3's committed code includes the new byte.
- R9: With chain_mode = 1, writes with address bit 3 = 1 change no register.
- R10: With chain_mode = 1, high-nibble writes to any channel and low-byte writes to channels 0..2 only fill staging registers and commit nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_addr | input | 16 | Write address: base tag in bits 15..4, commit bit 3, channel 2..1, half select 0 |
| wr_data | input | 8 | Write data, right-justified |
| wr_stb | input | 1 | Write strobe, one write per high cycle |
| chain_mode | input | 1 | 1 = low-byte write to last channel commits all; broadcast address disabled |
| code_out | output | 48 | Four 12-bit codes; channel n in bits 12n+11..12n |

## Verification
In chained mode, the staging write and the global commit land in the same clock edge, and they are the two functions that can coincide. The bench first leaves channel 3 with a high nibble staged and other channels with pending values. It then issues the chained low-byte write. The check passes only if, one edge later, every output shows its staged value and channel 3 shows both the new byte and the earlier nibble. A commit that used the old staging value, or one that arrived a cycle late, would miss.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_LO   = 2'd1,
    WK_HI   = 2'd2,
    WK_ALL  = 2'd3
  } wr_kind_e;

  // Classify one bus cycle from the tag match, commit bit and half-select bit.
  function automatic wr_kind_e classify(input logic hit, input logic commit_bit,
                                        input logic half_bit);
    if (!hit)            return WK_NONE;
    else if (commit_bit) return WK_ALL;
    else if (half_bit)   return WK_HI;
    else                 return WK_LO;
  endfunction

endpackage

// File: rtl/dbl_addr_decode.sv
module dbl_addr_decode
  import dbl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hA500
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              stb,
  input  logic              chain,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic              upd
);
  localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int LOCAL_W = SEL_W + 2;
  localparam int CMT_BIT = SEL_W + 1;
  localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(NUM_CH - 1);

  logic             tag_hit;
  logic [SEL_W-1:0] sel;
  wr_kind_e         kind;

  assign tag_hit = stb && (addr[ADDR_W-1:LOCAL_W] == BASE_ADDR[ADDR_W-1:LOCAL_W]);
  assign sel     = addr[SEL_W:1];
  assign kind    = classify(tag_hit, addr[CMT_BIT], addr[0]);

  // In chained mode the commit address is dead; the last low write commits.
  assign upd = chain ? ((kind == WK_LO) && (sel == LAST_CH)) : (kind == WK_ALL);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign lo_we[i] = (kind == WK_LO) && (sel == SEL_W'(i));
    assign hi_we[i] = (kind == WK_HI) && (sel == SEL_W'(i));
  end

endmodule

// File: rtl/dbl_channel.sv
module dbl_channel #(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              upd,
  input  logic [BYTE_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  localparam int HI_W = CODE_W - BYTE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  function automatic logic [CODE_W-1:0] join_code(input logic [HI_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [BYTE_W-1:0] stage_lo, stage_lo_nx;
  logic [HI_W-1:0]   stage_hi, stage_hi_nx;
  logic [CODE_W-1:0] staged_w;

  assign stage_lo_nx = lo_we ? data : stage_lo;
  assign stage_hi_nx = hi_we ? data[HI_W-1:0] : stage_hi;
  // Forward the write of this cycle so a chained commit carries the new byte.
  assign staged_w    = join_code(stage_hi_nx, stage_lo_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= '0;
      stage_hi <= '0;
      code     <= MID_CODE;
    end else begin
      stage_lo <= stage_lo_nx;
      stage_hi <= stage_hi_nx;
      if (upd) code <= staged_w;
    end
  end

endmodule

// File: rtl/dac_bus_loader.sv
module dac_bus_loader #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hA500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     wr_stb,
  input  logic                     chain_mode,
  output logic [NUM_CH*CODE_W-1:0] code_out
);
  logic [NUM_CH-1:0] lo_we_w;
  logic [NUM_CH-1:0] hi_we_w;
  logic              upd_w;

  dbl_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR)
  ) dec_i (
    .addr(wr_addr), .stb(wr_stb), .chain(chain_mode),
    .lo_we(lo_we_w), .hi_we(hi_we_w), .upd(upd_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbl_channel #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .lo_we(lo_we_w[c]), .hi_we(hi_we_w[c]), .upd(upd_w),
      .data(wr_data),
      .code(code_out[c*CODE_W +: CODE_W])
    );
  end

endmodule

// File: rtl/dbl_checker.sv
module dbl_checker #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hA500
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     wr_stb,
  input logic                     chain_mode,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        lo_we_w,
  input logic [NUM_CH-1:0]        hi_we_w,
  input logic                     upd_w
);
  localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int LOCAL_W = SEL_W + 2;
  localparam int CMT_BIT = SEL_W + 1;

  assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_w |=> $stable(code_out));

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_we_w, hi_we_w}));

  assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(code_out));

  assert_foreign_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr[ADDR_W-1:LOCAL_W] != BASE_ADDR[ADDR_W-1:LOCAL_W]))
      |=> $stable(code_out));

  assert_chain_dead_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && wr_addr[CMT_BIT]) |-> (!upd_w && lo_we_w == '0 && hi_we_w == '0));

  assert_chain_commit_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && upd_w) |-> lo_we_w[NUM_CH-1]);

  assert_hi_never_commits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_mode && (hi_we_w != '0)) |-> !upd_w);

endmodule

bind dac_bus_loader dbl_checker #(
  .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_stb(wr_stb),
  .chain_mode(chain_mode), .code_out(code_out),
  .lo_we_w(lo_we_w), .hi_we_w(hi_we_w), .upd_w(upd_w)
);

// File: tb/dac_bus_loader_tb_top.sv
module dac_bus_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_stb = 1'b0;
  logic        chain_mode = 1'b0;
  logic [47:0] code_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dac_bus_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_stb(wr_stb), .chain_mode(chain_mode), .code_out(code_out)
  );

  // {req[3:0], chain, stb, addr[15:0], data[7:0], expected {ch3,ch2,ch1,ch0}}
  localparam int NVEC = 16;
  localparam logic [77:0] VEC [NVEC] = '{
    {4'd4,  1'b0, 1'b1, 16'hA500, 8'h34, 48'h800_800_800_800}, // R2 R4 ch0 low
    {4'd3,  1'b0, 1'b1, 16'hA501, 8'hF1, 48'h800_800_800_800}, // R3 upper nibble dropped
    {4'd2,  1'b0, 1'b1, 16'hA502, 8'hCD, 48'h800_800_800_800}, // R2 ch1 low
    {4'd3,  1'b0, 1'b1, 16'hA505, 8'h0A, 48'h800_800_800_800}, // R3 ch2 high
    {4'd2,  1'b0, 1'b1, 16'hA506, 8'h77, 48'h800_800_800_800}, // R2 ch3 low, no commit
    {4'd3,  1'b0, 1'b1, 16'hA507, 8'h25, 48'h800_800_800_800}, // R3 ch3 high
    {4'd6,  1'b0, 1'b1, 16'hA4F8, 8'h00, 48'h800_800_800_800}, // R6 foreign commit
    {4'd7,  1'b0, 1'b0, 16'hA508, 8'h00, 48'h800_800_800_800}, // R7 strobe low
    {4'd5,  1'b0, 1'b1, 16'hA50D, 8'h00, 48'h577_A00_0CD_134}, // R5 commit, low bits ignored
    {4'd4,  1'b0, 1'b1, 16'hA500, 8'h99, 48'h577_A00_0CD_134}, // R4 staged only
    {4'd6,  1'b0, 1'b1, 16'hA4F1, 8'h0F, 48'h577_A00_0CD_134}, // R6 foreign high write
    {4'd5,  1'b0, 1'b1, 16'hA508, 8'h00, 48'h577_A00_0CD_199}, // R5 shows R6 had no effect
    {4'd10, 1'b1, 1'b1, 16'hA504, 8'h11, 48'h577_A00_0CD_199}, // R10 ch2 low in chain
    {4'd9,  1'b1, 1'b1, 16'hA508, 8'h00, 48'h577_A00_0CD_199}, // R9 dead commit address
    {4'd10, 1'b1, 1'b1, 16'hA507, 8'h06, 48'h577_A00_0CD_199}, // R10 ch3 high in chain
    {4'd8,  1'b1, 1'b1, 16'hA506, 8'hEE, 48'h6EE_A11_0CD_199}  // R8 chained commit
  };

  task automatic check(input int req, input logic [47:0] exp);
    checks++;
    if (code_out !== exp) begin
      errors++;
      $display("FAIL R%0d code_out=%h expected=%h", req, code_out, exp);
    end
  endtask

  task automatic bus_cycle(input logic ch, input logic stb, input logic [15:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    chain_mode = ch; wr_stb = stb; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 48'h800_800_800_800);            // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 48'h800_800_800_800);            // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      bus_cycle(VEC[i][73], VEC[i][72], VEC[i][71:56], VEC[i][55:48]);
      check(int'(VEC[i][77:74]), VEC[i][47:0]);
    end

    // R1: reset mid-run restores mid code and clears staging.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(1, 48'h800_800_800_800);
    rst_n = 1'b1;
    bus_cycle(1'b0, 1'b1, 16'hA508, 8'h00);
    check(1, 48'h000_000_000_000);            // R1 staging was zero

    // R8: chained commit again with staged high nibbles on several channels.
    bus_cycle(1'b1, 1'b1, 16'hA503, 8'hB3);  // ch1 high = 3
    bus_cycle(1'b1, 1'b1, 16'hA507, 8'h0F);  // ch3 high = F
    check(10, 48'h000_000_000_000);
    bus_cycle(1'b1, 1'b1, 16'hA506, 8'h01);
    check(8, 48'hF01_000_300_000);

    finish_run();
  end

endmodule